// File: doc/BRIEF.md
# Integer Execute Stage with Immediate Handling

This block is the execute stage of a small 32-bit load/store integer core. Each cycle it takes two register operands, a 16-bit immediate, a 5-bit constant shift count and a 4-bit operation code. It produces a 32-bit result and a flag that reports whether the two register operands are equal. Both outputs are registered and appear one clock after the inputs.

The immediate is widened inside the block. The form of the widening depends on the operation. Signed arithmetic and address forms copy the immediate's top bit upward. Logical forms fill the upper half with zeros. The upper-load form places the immediate in the high half of the word.

The equality flag is taken from the difference of the two register operands, whatever operation is selected, so that a branch unit can use it directly. Overflow is not trapped.

Top module: `int_exec_unit`

## Requirements
- R1: Code 0 yields src_a + src_b and code 1 yields src_a - src_b, both wrapping modulo 2^32.
- R2: Code 2 yields src_a AND src_b and code 3 yields src_a OR src_b, bit by bit.
- R3: Code 4 yields 1 when src_a is less than src_b as two's-complement values, else 0. Code 6 does the same with the sign-widened immediate in place of src_b.
- R4: Code 5 yields src_a plus the immediate widened by copying bit 15 into bits 31:16.
- R5: Code 7 yields src_a AND the immediate and code 8 yields src_a OR the immediate, with the immediate's bits 31:16 taken as zero.
- R6: Code 9 yields the immediate in bits 31:16 and zeros in bits 15:0. src_a and src_b have no effect on it.
- R7: Code 10 shifts src_b left and code 11 shifts src_b right by shamt positions, and vacated bits are filled with zeros.
- R8: Code 12 yields the memory address src_a plus the sign-widened immediate, so offsets from -32768 to +32767 reach below and above the base.
- R9: The zero output is 1 exactly when src_a - src_b is zero. This holds for every operation code.
- R10: result and zero update one rising edge after the inputs. While rst is high at a rising edge, both outputs become 0.
- R11: Codes 13, 14 and 15 yield a result of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 4 | Operation code (see requirements) |
| src_a | input | 32 | First register operand / address base |
| src_b | input | 32 | Second register operand / shift source |
| imm | input | 16 | Immediate or address offset |
| shamt | input | 5 | Constant shift count |
| result | output | 32 | Registered result |
| zero | output | 1 | Registered equality flag of src_a and src_b |

## Verification
Every result and every zero flag is due exactly one rising edge after its operands are applied, because there is a single register stage. The bench changes the inputs on the falling edge and lets one rising edge pass. It then samples both outputs a nanosecond later, before the next set of inputs is applied, so each check is tied to the operands that produced it. The reset check raises rst alongside non-zero operands and samples after that same single edge.

// File: rtl/exec_pkg.sv
package exec_pkg;
  localparam int XLEN  = 32;
  localparam int IMMW  = 16;

  typedef enum logic [3:0] {
    EX_ADD   = 4'd0,
    EX_SUB   = 4'd1,
    EX_AND   = 4'd2,
    EX_OR    = 4'd3,
    EX_SLT   = 4'd4,
    EX_ADDI  = 4'd5,
    EX_SLTI  = 4'd6,
    EX_ANDI  = 4'd7,
    EX_ORI   = 4'd8,
    EX_LUI   = 4'd9,
    EX_SLL   = 4'd10,
    EX_SRL   = 4'd11,
    EX_EADDR = 4'd12,
    EX_RSV13 = 4'd13,
    EX_RSV14 = 4'd14,
    EX_RSV15 = 4'd15
  } exec_op_e;

  typedef enum logic [1:0] {
    EXT_SIGN  = 2'd0,
    EXT_ZERO  = 2'd1,
    EXT_UPPER = 2'd2
  } ext_kind_e;
endpackage

// File: rtl/exec_imm_ext.sv
module exec_imm_ext
  import exec_pkg::*;
#(
  parameter int DATA_W = XLEN,
  parameter int IMM_W  = IMMW
) (
  input  exec_op_e            op,
  input  logic [IMM_W-1:0]    imm,
  output logic [DATA_W-1:0]   ext_imm
);
  localparam int PAD_W = DATA_W - IMM_W;

  ext_kind_e kind;

  // Logical immediates take zero fill; load-upper lifts the field; the rest sign-fill.
  always_comb begin
    unique case (op)
      EX_ANDI, EX_ORI: kind = EXT_ZERO;
      EX_LUI:          kind = EXT_UPPER;
      default:         kind = EXT_SIGN;
    endcase
  end

  always_comb begin
    unique case (kind)
      EXT_ZERO:  ext_imm = {{PAD_W{1'b0}}, imm};
      EXT_UPPER: ext_imm = {imm, {PAD_W{1'b0}}};
      default:   ext_imm = {{PAD_W{imm[IMM_W-1]}}, imm};
    endcase
  end
endmodule

// File: rtl/exec_shifter.sv
module exec_shifter #(
  parameter int DATA_W = 32,
  parameter int AMT_W  = $clog2(DATA_W),
  parameter bit STAGED = 1'b1
) (
  input  logic [DATA_W-1:0] value,
  input  logic [AMT_W-1:0]  amount,
  input  logic              to_right,
  output logic [DATA_W-1:0] shifted
);
  generate
    if (STAGED) begin : g_staged
      // Logarithmic network: stage k moves by 2^k when amount bit k is set.
      logic [DATA_W-1:0] stage_v [0:AMT_W];
      assign stage_v[0] = value;
      for (genvar k = 0; k < AMT_W; k++) begin : g_stage
        localparam int STEP = 1 << k;
        always_comb begin
          if (!amount[k])
            stage_v[k+1] = stage_v[k];
          else if (to_right)
            stage_v[k+1] = {{STEP{1'b0}}, stage_v[k][DATA_W-1:STEP]};
          else
            stage_v[k+1] = {stage_v[k][DATA_W-1-STEP:0], {STEP{1'b0}}};
        end
      end
      assign shifted = stage_v[AMT_W];
    end else begin : g_flat
      assign shifted = to_right ? (value >> amount) : (value << amount);
    end
  endgenerate
endmodule

// File: rtl/exec_alu.sv
module exec_alu
  import exec_pkg::*;
#(
  parameter int DATA_W = XLEN
) (
  input  exec_op_e          op,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [DATA_W-1:0] ext_imm,
  input  logic [DATA_W-1:0] shift_out,
  output logic [DATA_W-1:0] alu_res
);
  function automatic logic [DATA_W-1:0] f_add(input logic [DATA_W-1:0] x, input logic [DATA_W-1:0] y);
    return x + y;
  endfunction

  function automatic logic [DATA_W-1:0] f_lt_signed(input logic [DATA_W-1:0] x, input logic [DATA_W-1:0] y);
    return {{(DATA_W-1){1'b0}}, ($signed(x) < $signed(y))};
  endfunction

  always_comb begin
    unique case (op)
      EX_ADD:             alu_res = f_add(opnd_a, opnd_b);
      EX_SUB:             alu_res = opnd_a - opnd_b;
      EX_AND:             alu_res = opnd_a & opnd_b;
      EX_OR:              alu_res = opnd_a | opnd_b;
      EX_SLT:             alu_res = f_lt_signed(opnd_a, opnd_b);
      EX_ADDI, EX_EADDR:  alu_res = f_add(opnd_a, ext_imm);
      EX_SLTI:            alu_res = f_lt_signed(opnd_a, ext_imm);
      EX_ANDI:            alu_res = opnd_a & ext_imm;
      EX_ORI:             alu_res = opnd_a | ext_imm;
      EX_LUI:             alu_res = ext_imm;
      EX_SLL, EX_SRL:     alu_res = shift_out;
      default:            alu_res = '0;
    endcase
  end
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import exec_pkg::*;
#(
  parameter int DATA_W  = XLEN,
  parameter int IMM_W   = IMMW,
  parameter bit STAGED  = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [3:0]                op_sel,
  input  logic [DATA_W-1:0]         src_a,
  input  logic [DATA_W-1:0]         src_b,
  input  logic [IMM_W-1:0]          imm,
  input  logic [$clog2(DATA_W)-1:0] shamt,
  output logic [DATA_W-1:0]         result,
  output logic                      zero
);
  localparam int SH_W = $clog2(DATA_W);

  exec_op_e          op;
  logic [DATA_W-1:0] ext_imm;
  logic [DATA_W-1:0] shift_out;
  logic [DATA_W-1:0] alu_res;
  logic [DATA_W-1:0] diff_ab;
  logic              diff_zero;

  assign op        = exec_op_e'(op_sel);
  assign diff_ab   = src_a - src_b;
  assign diff_zero = (diff_ab == '0);

  exec_imm_ext #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_ext (
    .op      (op),
    .imm     (imm),
    .ext_imm (ext_imm)
  );

  exec_shifter #(.DATA_W(DATA_W), .AMT_W(SH_W), .STAGED(STAGED)) u_shift (
    .value    (src_b),
    .amount   (shamt),
    .to_right (op == EX_SRL),
    .shifted  (shift_out)
  );

  exec_alu #(.DATA_W(DATA_W)) u_alu (
    .op        (op),
    .opnd_a    (src_a),
    .opnd_b    (src_b),
    .ext_imm   (ext_imm),
    .shift_out (shift_out),
    .alu_res   (alu_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      zero   <= 1'b0;
    end else begin
      result <= alu_res;
      zero   <= diff_zero;
    end
  end

  // R10: a reset edge leaves both outputs cleared
  p_reset_clears_r10: assert property (@(posedge clk)
    rst |=> (result == '0 && zero == 1'b0));

  // R9: after a subtract, the flag agrees with the registered difference
  p_zero_matches_sub_r9: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 4'd1) |=> (zero == (result == '0)));

  // R3: set-less-than forms leave only bit 0 free
  p_slt_boolean_r3: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 4'd4 || op_sel == 4'd6) |=> (result[DATA_W-1:1] == '0));

  // R5: AND with a zero-filled immediate clears the upper half
  p_andi_upper_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 4'd7) |=> (result[DATA_W-1:IMM_W] == '0));

  // R6: load-upper leaves the low half clear
  p_lui_low_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 4'd9) |=> (result[DATA_W-IMM_W-1:0] == '0));

  // R7: a non-zero right shift brings a zero into the top bit
  p_srl_top_fill_r7: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 4'd11 && shamt != '0) |=> (result[DATA_W-1] == 1'b0));

  // R7: a non-zero left shift brings a zero into bit 0
  p_sll_low_fill_r7: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 4'd10 && shamt != '0) |=> (result[0] == 1'b0));

  // R11: unassigned codes give zero
  p_reserved_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (op_sel >= 4'd13) |=> (result == '0));
endmodule

// File: tb/int_exec_unit_bench.sv
`timescale 1ns/1ps
module int_exec_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op_sel = '0;
  logic [31:0] src_a = '0;
  logic [31:0] src_b = '0;
  logic [15:0] imm = '0;
  logic [4:0]  shamt = '0;
  logic [31:0] result;
  logic        zero;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  int_exec_unit u_int_exec_unit (
    .clk(clk), .rst(rst), .op_sel(op_sel), .src_a(src_a), .src_b(src_b),
    .imm(imm), .shamt(shamt), .result(result), .zero(zero)
  );

  function automatic logic [31:0] sx(input logic [15:0] v);
    return v[15] ? (32'hFFFF0000 | {16'h0, v}) : {16'h0, v};
  endfunction

  function automatic logic [31:0] lt(input logic [31:0] x, input logic [31:0] y);
    if (x[31] != y[31]) return {31'd0, x[31]};
    return {31'd0, (x < y)};
  endfunction

  function automatic logic [31:0] model(input logic [3:0] o, input logic [31:0] a,
                                        input logic [31:0] b, input logic [15:0] i,
                                        input logic [4:0] s);
    case (o)
      4'd0:  return a + b;
      4'd1:  return a + (~b) + 32'd1;
      4'd2:  return a & b;
      4'd3:  return a | b;
      4'd4:  return lt(a, b);
      4'd5:  return a + sx(i);
      4'd6:  return lt(a, sx(i));
      4'd7:  return a & {16'h0, i};
      4'd8:  return a | {16'h0, i};
      4'd9:  return {i, 16'h0};
      4'd10: return b * (32'd1 << s);
      4'd11: return b / (32'd1 << s);
      4'd12: return a + sx(i);
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] o);
    case (o)
      4'd0, 4'd1:   return "R1";
      4'd2, 4'd3:   return "R2";
      4'd4, 4'd6:   return "R3";
      4'd5:         return "R4";
      4'd7, 4'd8:   return "R5";
      4'd9:         return "R6";
      4'd10, 4'd11: return "R7";
      4'd12:        return "R8";
      default:      return "R11";
    endcase
  endfunction

  task automatic check32(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic run(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b,
                     input logic [15:0] i, input logic [4:0] s);
    @(negedge clk);
    op_sel = o; src_a = a; src_b = b; imm = i; shamt = s;
    @(posedge clk);
    #1;
    check32(tag_of(o), result, model(o, a, b, i, s));
    // R9: equality flag from the operand difference, any code
    check32("R9", {31'd0, zero}, {31'd0, (a == b)});
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // R10: reset with live operands clears both outputs
    @(negedge clk);
    op_sel = 4'd0; src_a = 32'h5; src_b = 32'h5; imm = 16'h1234; shamt = 5'd3;
    @(posedge clk); #1;
    check32("R10", result, 32'd0);
    check32("R10", {31'd0, zero}, 32'd0);
    @(negedge clk); rst = 1'b0;

    run(4'd0, 32'hFFFFFFFF, 32'h1, 16'h0, 5'd0);        // R1 wrap
    run(4'd1, 32'h0, 32'h1, 16'h0, 5'd0);               // R1 wrap below zero
    run(4'd1, 32'h1234, 32'h1234, 16'h0, 5'd0);         // R9 equal operands
    run(4'd2, 32'hF0F0_00FF, 32'h0FF0_0F0F, 16'h0, 5'd0);
    run(4'd3, 32'hF0F0_00FF, 32'h0FF0_0F0F, 16'h0, 5'd0);
    run(4'd4, 32'hFFFFFFFE, 32'h1, 16'h0, 5'd0);        // R3 -2 < 1
    run(4'd4, 32'h1, 32'hFFFFFFFE, 16'h0, 5'd0);        // R3 1 !< -2
    run(4'd4, 32'h7, 32'h7, 16'h0, 5'd0);               // R3 equal
    run(4'd6, 32'hFFFF63C0, 32'h0, 16'h8000, 5'd0);     // R3 -40000 < -32768
    run(4'd5, 32'h10, 32'h0, 16'hFFFF, 5'd0);           // R4 minus one
    run(4'd5, 32'h0, 32'h0, 16'h7FFF, 5'd0);            // R4 largest positive
    run(4'd7, 32'hFFFFFFFF, 32'h0, 16'hF0F0, 5'd0);     // R5 zero fill
    run(4'd8, 32'h0, 32'h0, 16'h8001, 5'd0);            // R5 top bit not copied
    run(4'd9, 32'hDEADBEEF, 32'hCAFEF00D, 16'hABCD, 5'd0); // R6 operands ignored
    run(4'd10, 32'h0, 32'h1, 16'h0, 5'd31);             // R7 max left
    run(4'd11, 32'h0, 32'h80000000, 16'h0, 5'd31);      // R7 max right
    run(4'd11, 32'h0, 32'hFFFFFFFF, 16'h0, 5'd0);       // R7 zero count
    run(4'd12, 32'h10, 32'h0, 16'hFFF8, 5'd0);          // R8 negative offset
    run(4'd12, 32'h1000, 32'h0, 16'h8000, 5'd0);        // R8 lowest offset
    run(4'd13, 32'h3, 32'h3, 16'hFFFF, 5'd7);           // R11
    run(4'd15, 32'hFFFFFFFF, 32'h1, 16'hFFFF, 5'd7);    // R11

    for (int n = 0; n < 600; n++) begin
      logic [31:0] ra, rb;
      ra = $urandom;
      rb = ($urandom % 8 == 0) ? ra : $urandom;
      run(4'($urandom % 16), ra, rb, 16'($urandom), 5'($urandom));
    end

    // R10: reset raised in mid-stream
    @(negedge clk);
    rst = 1'b1; op_sel = 4'd3; src_a = 32'hFFFF; src_b = 32'hFFFF;
    @(posedge clk); #1;
    check32("R10", result, 32'd0);
    check32("R10", {31'd0, zero}, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule